// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for an on-chip packet buffer that is split into fixed 256-byte pages. A host sends one-cycle commands: reserve a run of pages, wipe the whole map, free a packet, release the oldest received packet, or queue a packet for transmission. Every packet is a run of adjacent pages. Its packet number is the index of its first page, and a per-page length table records how many pages were granted, so a later free returns exactly that run.

Reservation uses a first-fit scan that looks at one page per clock. A request that cannot be met when it arrives stays outstanding. It is retried whenever pages are returned and is granted with no further host action. Three small queues of packet numbers link the block to the MAC side. One holds packets waiting to transmit. A completion queue holds only the packets whose transmission failed, because successful ones give their pages back on their own. The third holds received packets waiting for the host.

Top module: `pkt_page_alloc`

## Requirements
- R1: An ALLOC command (cmd_op = 1, cmd_arg = page count minus one) grants the lowest-numbered run of cmd_arg+1 adjacent free pages. res_pkt becomes the first page of that run, res_failed goes to 0 and alloc_done goes to 1. alloc_done returns to 0 when the next ALLOC is accepted.
- R2: An ALLOC that asks for more pages than NUM_PAGES fails at once. On the next cycle res_failed is 1, alloc_done is 0 and busy is 0, and the request is not kept.
- R3: An ALLOC that fits in the buffer but finds no free run sets res_failed and stays outstanding. When later frees create a large enough run, it is granted with no further command. Only one request is outstanding at a time, and a newer ALLOC replaces it.
- R4: busy is 1 from the cycle after an accepted ALLOC or RESET until that work ends. Commands presented while busy is 1 are ignored.
- R5: A RESET command (cmd_op = 2) empties all three queues in the next cycle, drops any outstanding request, marks every page free and holds busy for exactly NUM_PAGES cycles.
- R6: A FREE command (cmd_op = 4, cmd_arg = packet number) returns exactly the pages granted to that packet. A number that is not the first page of a live packet is ignored. If the packet is at the head of the completion queue, it is also removed from that queue.
- R7: An ENQUEUE command (cmd_op = 5, cmd_arg = packet number) appends the packet to the transmit queue. The queue head is presented on tx_req_pkt with tx_req_valid, and tx_take removes it, in first-in first-out order.
- R8: A tx_done pulse with tx_ok = 1 frees that packet's pages and leaves the completion queue untouched. A tx_done pulse with tx_ok = 0 pushes the packet onto the completion queue and keeps its pages.
- R9: An rx_done pulse pushes rx_in_pkt onto the receive queue. A RELEASE command (cmd_op = 3) frees the head packet and removes it from the queue. RELEASE with an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd_op | input | 3 | Command code |
| cmd_arg | input | PKT_W | Page count minus one, or packet number |
| busy | output | 1 | Command work in progress |
| res_pkt | output | PKT_W | Last granted packet number |
| res_failed | output | 1 | Last request could not be granted |
| alloc_done | output | 1 | A request has been granted |
| tx_req_valid | output | 1 | Transmit queue not empty |
| tx_req_pkt | output | PKT_W | Transmit queue head |
| tx_take | input | 1 | MAC removes the transmit queue head |
| tx_done | input | 1 | MAC finished a transmission |
| tx_ok | input | 1 | That transmission succeeded |
| tx_done_pkt | input | PKT_W | Packet the MAC finished |
| txc_empty | output | 1 | Completion queue empty |
| txc_pkt | output | PKT_W | Completion queue head |
| rx_done | input | 1 | MAC stored a received packet |
| rx_in_pkt | input | PKT_W | Packet holding the received frame |
| rx_empty | output | 1 | Receive queue empty |
| rx_pkt | output | PKT_W | Receive queue head |

## Verification
A page that the map wrongly shows as used or free shows up at the ports on the next grant. res_pkt then names a different first page than a first-fit search over the true map would give, or a request that should fit reports res_failed. A wrong length entry stays hidden until that packet is freed, and then shows in the packet number of the next grant. The bench therefore follows every free, release and automatic return with a reservation whose expected packet number depends on exactly which pages came back. It also times busy across a wipe and across commands presented while busy.

// File: rtl/pba_pkg.sv
package pba_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_RESET   = 3'd2,
      OP_RELEASE = 3'd3,
      OP_FREE    = 3'd4,
      OP_ENQUEUE = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SCAN,
      ST_WIPE
   } st_e;
endpackage

// File: rtl/pba_fifo.sv
module pba_fifo #(
   parameter int W     = 6,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   initial begin
      if (DEPTH < 1) $error("pba_fifo: DEPTH must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] d_q;
         logic         v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q <= '0;
               v_q <= 1'b0;
            end else if (flush) begin
               v_q <= 1'b0;
            end else begin
               if (pop) v_q <= 1'b0;
               if (push && (!v_q || pop)) begin
                  d_q <= din;
                  v_q <= 1'b1;
               end
            end
         end
         assign dout  = d_q;
         assign empty = !v_q;
         assign full  = v_q;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] rd_q, wr_q;
         logic [AW:0]   cnt_q;
         logic          do_push, do_pop;

         assign empty   = (cnt_q == '0);
         assign full    = (cnt_q == (AW+1)'(DEPTH));
         assign do_push = push && !full;
         assign do_pop  = pop && !empty;
         assign dout    = mem[rd_q];

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_q] <= din;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else if (flush) begin
               rd_q  <= '0;
               wr_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
               if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
               case ({do_push, do_pop})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pba_page_map.sv
module pba_page_map
   import pba_pkg::*;
#(
   parameter int PKT_W     = 6,
   parameter int NUM_PAGES = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_alloc,
   input  logic [PKT_W-1:0] need_m1,
   input  logic             start_wipe,
   input  logic             fa_en,
   input  logic [PKT_W-1:0] fa_pkt,
   input  logic             fb_en,
   input  logic [PKT_W-1:0] fb_pkt,
   output logic             busy,
   output logic [PKT_W-1:0] res_pkt,
   output logic             res_failed,
   output logic             alloc_done
);
   localparam int PG_W = $clog2(NUM_PAGES);
   localparam int CW   = PKT_W + 1;
   localparam logic [CW-1:0]   NPC  = CW'(NUM_PAGES);
   localparam logic [PG_W-1:0] LAST = PG_W'(NUM_PAGES - 1);

   logic [NUM_PAGES-1:0]           used_q, head_q;
   logic [NUM_PAGES-1:0][PG_W-1:0] len_q;
   st_e                            st_q;
   logic [PG_W-1:0]                idx_q, base_q;
   logic [CW-1:0]                  run_q, need_q;
   logic                           pend_q, dirty_q;

   // scan step
   logic            cur_free, hit, last;
   logic [CW-1:0]   run_n;
   logic [PG_W-1:0] base_n;
   assign cur_free = !used_q[idx_q];
   assign run_n    = cur_free ? run_q + 1'b1 : '0;
   assign base_n   = (run_q == '0) ? idx_q : base_q;
   assign hit      = (st_q == ST_SCAN) && cur_free && (run_n == need_q);
   assign last     = (idx_q == LAST);

   // free ports: a packet number is valid only if it heads a live run
   logic [PG_W-1:0] fa_idx, fb_idx;
   logic            fa_ok, fb_ok, free_any;
   logic [CW-1:0]   fa_lo, fa_hi, fb_lo, fb_hi;
   assign fa_idx   = fa_pkt[PG_W-1:0];
   assign fb_idx   = fb_pkt[PG_W-1:0];
   assign fa_ok    = fa_en && ({1'b0, fa_pkt} < NPC) && head_q[fa_idx];
   assign fb_ok    = fb_en && ({1'b0, fb_pkt} < NPC) && head_q[fb_idx];
   assign fa_lo    = CW'(fa_idx);
   assign fb_lo    = CW'(fb_idx);
   assign fa_hi    = fa_lo + CW'(len_q[fa_idx]);
   assign fb_hi    = fb_lo + CW'(len_q[fb_idx]);
   assign free_any = fa_ok || fb_ok;

   logic [NUM_PAGES-1:0] grant_v, free_v, wipe_v;
   generate
      for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
         assign grant_v[i] = hit && (CW'(i) >= CW'(base_n)) && (CW'(i) < CW'(base_n) + need_q);
         assign free_v[i]  = (fa_ok && CW'(i) >= fa_lo && CW'(i) <= fa_hi) ||
                             (fb_ok && CW'(i) >= fb_lo && CW'(i) <= fb_hi);
         assign wipe_v[i]  = (st_q == ST_WIPE) && (idx_q == PG_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used_q <= '0;
         head_q <= '0;
         len_q  <= '0;
      end else begin
         for (int i = 0; i < NUM_PAGES; i++) begin
            if (wipe_v[i]) begin
               used_q[i] <= 1'b0;
               head_q[i] <= 1'b0;
            end else if (grant_v[i]) begin
               used_q[i] <= 1'b1;
               head_q[i] <= (PG_W'(i) == base_n);
               if (PG_W'(i) == base_n) len_q[i] <= PG_W'(need_q - 1'b1);
            end else if (free_v[i]) begin
               used_q[i] <= 1'b0;
               head_q[i] <= 1'b0;
            end
         end
      end
   end

   logic rescan;
   assign rescan = (st_q == ST_IDLE) && pend_q && dirty_q && !start_alloc && !start_wipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         idx_q      <= '0;
         base_q     <= '0;
         run_q      <= '0;
         need_q     <= '0;
         pend_q     <= 1'b0;
         dirty_q    <= 1'b0;
         res_pkt    <= '0;
         res_failed <= 1'b0;
         alloc_done <= 1'b0;
      end else begin
         dirty_q <= ((start_alloc || start_wipe || rescan) ? 1'b0 : dirty_q) | free_any;
         if (start_wipe) begin
            st_q       <= ST_WIPE;
            idx_q      <= '0;
            pend_q     <= 1'b0;
            res_pkt    <= '0;
            res_failed <= 1'b0;
            alloc_done <= 1'b0;
         end else if (start_alloc) begin
            alloc_done <= 1'b0;
            if ({1'b0, need_m1} >= NPC) begin
               res_failed <= 1'b1;
               pend_q     <= 1'b0;
            end else begin
               st_q   <= ST_SCAN;
               idx_q  <= '0;
               run_q  <= '0;
               need_q <= {1'b0, need_m1} + 1'b1;
               pend_q <= 1'b1;
            end
         end else begin
            case (st_q)
               ST_SCAN: begin
                  if (hit) begin
                     st_q       <= ST_IDLE;
                     pend_q     <= 1'b0;
                     res_pkt    <= PKT_W'(base_n);
                     res_failed <= 1'b0;
                     alloc_done <= 1'b1;
                  end else if (last) begin
                     res_failed <= 1'b1;
                     idx_q      <= '0;
                     run_q      <= '0;
                     if (!dirty_q) st_q <= ST_IDLE;
                     else          dirty_q <= free_any;
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     run_q  <= run_n;
                     base_q <= base_n;
                  end
               end
               ST_WIPE: begin
                  if (last) st_q <= ST_IDLE;
                  else      idx_q <= idx_q + 1'b1;
               end
               default: begin
                  if (rescan) begin
                     st_q  <= ST_SCAN;
                     idx_q <= '0;
                     run_q <= '0;
                  end
               end
            endcase
         end
      end
   end

   assign busy = (st_q != ST_IDLE) || (pend_q && dirty_q);
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
   import pba_pkg::*;
#(
   parameter int PKT_W     = 6,
   parameter int NUM_PAGES = 18,
   parameter int Q_DEPTH   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [PKT_W-1:0] cmd_arg,
   output logic             busy,
   output logic [PKT_W-1:0] res_pkt,
   output logic             res_failed,
   output logic             alloc_done,
   output logic             tx_req_valid,
   output logic [PKT_W-1:0] tx_req_pkt,
   input  logic             tx_take,
   input  logic             tx_done,
   input  logic             tx_ok,
   input  logic [PKT_W-1:0] tx_done_pkt,
   output logic             txc_empty,
   output logic [PKT_W-1:0] txc_pkt,
   input  logic             rx_done,
   input  logic [PKT_W-1:0] rx_in_pkt,
   output logic             rx_empty,
   output logic [PKT_W-1:0] rx_pkt
);
   initial begin
      if (NUM_PAGES < 2)          $error("pkt_page_alloc: NUM_PAGES must be at least 2");
      if (NUM_PAGES > 2**PKT_W)   $error("pkt_page_alloc: PKT_W too narrow for NUM_PAGES");
      if (Q_DEPTH < 1)            $error("pkt_page_alloc: Q_DEPTH must be at least 1");
   end

   op_e  op;
   logic acc;
   assign op  = op_e'(cmd_op);
   assign acc = cmd_valid && !busy;

   logic start_alloc, start_wipe, host_free, host_rel;
   assign start_alloc = acc && (op == OP_ALLOC);
   assign start_wipe  = acc && (op == OP_RESET);
   assign host_free   = acc && (op == OP_FREE);
   assign host_rel    = acc && (op == OP_RELEASE) && !rx_empty;

   logic txq_empty, txq_full, txc_full, rxq_full;

   pba_page_map #(.PKT_W(PKT_W), .NUM_PAGES(NUM_PAGES)) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_alloc (start_alloc),
      .need_m1     (cmd_arg),
      .start_wipe  (start_wipe),
      .fa_en       (host_free || host_rel),
      .fa_pkt      (host_free ? cmd_arg : rx_pkt),
      .fb_en       (tx_done && tx_ok),
      .fb_pkt      (tx_done_pkt),
      .busy        (busy),
      .res_pkt     (res_pkt),
      .res_failed  (res_failed),
      .alloc_done  (alloc_done)
   );

   pba_fifo #(.W(PKT_W), .DEPTH(Q_DEPTH)) u_txq (
      .clk (clk), .rst_n (rst_n), .flush (start_wipe),
      .push (acc && (op == OP_ENQUEUE)), .din (cmd_arg),
      .pop (tx_take && !txq_empty), .dout (tx_req_pkt),
      .empty (txq_empty), .full (txq_full)
   );

   pba_fifo #(.W(PKT_W), .DEPTH(Q_DEPTH)) u_txc (
      .clk (clk), .rst_n (rst_n), .flush (start_wipe),
      .push (tx_done && !tx_ok), .din (tx_done_pkt),
      .pop (host_free && !txc_empty && (txc_pkt == cmd_arg)), .dout (txc_pkt),
      .empty (txc_empty), .full (txc_full)
   );

   pba_fifo #(.W(PKT_W), .DEPTH(Q_DEPTH)) u_rxq (
      .clk (clk), .rst_n (rst_n), .flush (start_wipe),
      .push (rx_done), .din (rx_in_pkt),
      .pop (host_rel), .dout (rx_pkt),
      .empty (rx_empty), .full (rxq_full)
   );

   logic unused_full;
   assign unused_full  = txq_full ^ txc_full ^ rxq_full;
   assign tx_req_valid = !txq_empty;
endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk #(
   parameter int PKT_W     = 6,
   parameter int NUM_PAGES = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic [PKT_W-1:0] cmd_arg,
   input logic             busy,
   input logic             res_failed,
   input logic             alloc_done,
   input logic             tx_done,
   input logic             tx_ok,
   input logic             txc_empty,
   input logic             rx_done,
   input logic             rx_empty
);
   localparam logic [PKT_W:0] NPC = (PKT_W+1)'(NUM_PAGES);

   logic acc_alloc, acc_reset;
   assign acc_alloc = cmd_valid && !busy && (cmd_op == 3'd1);
   assign acc_reset = cmd_valid && !busy && (cmd_op == 3'd2);

   a_r4_busy_after_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      acc_alloc && ({1'b0, cmd_arg} < NPC) |=> busy);

   a_r2_oversize_fails_now: assert property (@(posedge clk) disable iff (!rst_n)
      acc_alloc && ({1'b0, cmd_arg} >= NPC) |=> res_failed && !alloc_done && !busy);

   a_r5_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      acc_reset |=> busy && txc_empty && rx_empty && !alloc_done);

   a_r1_done_not_failed: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_done |-> !res_failed);

   a_r1_grant_after_work: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alloc_done) |-> $past(busy));

   a_r8_failed_tx_queued: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done && !tx_ok && !acc_reset |=> !txc_empty);

   a_r9_rx_queued: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !acc_reset |=> !rx_empty);
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.PKT_W(PKT_W), .NUM_PAGES(NUM_PAGES)) u_chk (.*);

// File: tb/pkt_page_alloc_test.sv
`timescale 1ns/1ps
module pkt_page_alloc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [5:0] cmd_arg = '0;
   logic       busy, res_failed, alloc_done, tx_req_valid, txc_empty, rx_empty;
   logic [5:0] res_pkt, tx_req_pkt, txc_pkt, rx_pkt;
   logic       tx_take = 1'b0, tx_done = 1'b0, tx_ok = 1'b0, rx_done = 1'b0;
   logic [5:0] tx_done_pkt = '0, rx_in_pkt = '0;

   always #2 clk = ~clk;

   pkt_page_alloc uut (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
      .cmd_arg (cmd_arg), .busy (busy), .res_pkt (res_pkt), .res_failed (res_failed),
      .alloc_done (alloc_done), .tx_req_valid (tx_req_valid), .tx_req_pkt (tx_req_pkt),
      .tx_take (tx_take), .tx_done (tx_done), .tx_ok (tx_ok), .tx_done_pkt (tx_done_pkt),
      .txc_empty (txc_empty), .txc_pkt (txc_pkt), .rx_done (rx_done),
      .rx_in_pkt (rx_in_pkt), .rx_empty (rx_empty), .rx_pkt (rx_pkt)
   );

   int checks = 0;
   int fails  = 0;
   int exp_q[$];
   logic done_prev = 1'b0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: each rising alloc_done consumes one expected packet number
   always @(negedge clk) begin
      if (rst_n && alloc_done && !done_prev) begin
         if (exp_q.size() == 0) chk("R3 unexpected grant", int'(res_pkt), -1);
         else chk("R1 granted packet", int'(res_pkt), exp_q.pop_front());
      end
      done_prev = alloc_done;
   end

   task automatic issue(int op, int arg);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op[2:0];
      cmd_arg   = arg[5:0];
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic alloc_ok(int pages, int exp);
      exp_q.push_back(exp);
      issue(1, pages - 1);
      chk("R1 grant consumed", exp_q.size(), 0);
      chk("R1 not failed", int'(res_failed), 0);
   endtask

   task automatic mac_take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
   endtask

   task automatic mac_done(int pkt, bit ok);
      @(negedge clk); tx_done = 1'b1; tx_ok = ok; tx_done_pkt = pkt[5:0];
      @(negedge clk); tx_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 idle after reset", int'(busy), 0);
      chk("R1 done low after reset", int'(alloc_done), 0);
      chk("R8 completion empty after reset", int'(txc_empty), 1);
      chk("R9 rx empty after reset", int'(rx_empty), 1);
      chk("R7 tx queue empty after reset", int'(tx_req_valid), 0);

      // first fit on an empty map
      alloc_ok(1, 0);
      alloc_ok(3, 1);
      alloc_ok(2, 4);
      // R6 free returns exact run, then first fit reuses the hole
      issue(4, 1);
      alloc_ok(2, 1);
      alloc_ok(2, 6);          // page 3 alone is too small

      // R2 oversize request
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 6'd18;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R2 oversize failed", int'(res_failed), 1);
      chk("R2 oversize done low", int'(alloc_done), 0);
      chk("R2 oversize not busy", int'(busy), 0);

      // R3 deferred grant: used 0,1,2,4,5,6,7
      issue(1, 10);
      chk("R3 unmet request failed", int'(res_failed), 1);
      chk("R3 unmet request done low", int'(alloc_done), 0);
      issue(4, 4);
      chk("R3 still short after first free", int'(res_failed), 1);
      exp_q.push_back(3);
      issue(4, 6);
      chk("R3 deferred grant consumed", exp_q.size(), 0);
      chk("R3 deferred grant clears failed", int'(res_failed), 0);

      // R7 transmit order, R8 completion handling
      issue(5, 0);
      issue(5, 1);
      chk("R7 head valid", int'(tx_req_valid), 1);
      chk("R7 first in first out", int'(tx_req_pkt), 0);
      mac_take();
      @(negedge clk);
      chk("R7 second packet", int'(tx_req_pkt), 1);
      mac_take();
      @(negedge clk);
      chk("R7 queue drained", int'(tx_req_valid), 0);
      mac_done(0, 1'b1);
      @(negedge clk);
      chk("R8 success not queued", int'(txc_empty), 1);
      mac_done(1, 1'b0);
      @(negedge clk);
      chk("R8 failure queued", int'(txc_empty), 0);
      chk("R8 failed packet number", int'(txc_pkt), 1);
      alloc_ok(1, 0);          // pkt0 returned automatically
      alloc_ok(1, 14);         // pkt1 kept its pages
      issue(4, 1);
      chk("R6 free pops completion head", int'(txc_empty), 1);
      alloc_ok(2, 1);

      // R9 receive queue
      @(negedge clk); rx_done = 1'b1; rx_in_pkt = 6'd14;
      @(negedge clk); rx_done = 1'b0;
      chk("R9 rx not empty", int'(rx_empty), 0);
      chk("R9 rx head", int'(rx_pkt), 14);
      issue(3, 0);
      chk("R9 release pops", int'(rx_empty), 1);
      alloc_ok(1, 14);
      issue(3, 0);             // empty queue: must free nothing
      alloc_ok(1, 15);

      // R6 number that is not a live packet head
      issue(4, 5);
      alloc_ok(1, 16);

      // R4 command while busy is ignored
      exp_q.push_back(17);
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd1; cmd_arg = 6'd0;
      @(negedge clk); cmd_op = 3'd4; cmd_arg = 6'd16;
      chk("R4 busy during scan", int'(busy), 1);
      @(negedge clk); cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R4 grant after busy", exp_q.size(), 0);
      issue(1, 0);
      chk("R4 ignored free left page used", int'(res_failed), 1);

      // R5 wipe
      @(negedge clk); rx_done = 1'b1; rx_in_pkt = 6'd2;
      @(negedge clk); rx_done = 1'b0; cmd_valid = 1'b1; cmd_op = 3'd2;
      @(negedge clk); cmd_valid = 1'b0;
      chk("R5 rx flushed", int'(rx_empty), 1);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R5 busy cycles", n, 18);
      chk("R5 pending dropped", exp_q.size(), 0);
      @(negedge clk);
      chk("R5 no grant after wipe", int'(alloc_done), 0);
      alloc_ok(18, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule